// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned WIDTH-bit numbers one bit pair per accepted clock, using one full adder and a single carry flip-flop. The augend sits in register A and the addend in register B. Both registers shift toward the least significant end, so the full adder always sees the lowest unprocessed bit pair. The sum bit from each step goes back into the top of register A, and the carry-out is kept in the carry flop for the next step. After WIDTH accepted shifts, register A holds the WIDTH-bit sum and the carry flop holds its bit WIDTH.

While the addend shifts out of B, a new operand can be fed into the top of B one bit per step, least significant bit first. At the end of the pass, B holds that new operand. A rearm command clears the carry and restarts the step count without touching A or B, so a second pass adds the new operand to the running result in A. Starting with A cleared turns the block into a serial accumulator.

A small state machine controls the sequence. Its states are IDLE (after reset; shift requests are ignored), RUN (each shift request is accepted as one step) and FINISHED (the result is held and `done` is high). The transitions are: IDLE→RUN on start or rearm; RUN→RUN on a step that is not the last one; RUN→FINISHED on the WIDTH-th accepted step; FINISHED→RUN on start or rearm; and any state→RUN on start or rearm.

Top module: `serad_top`

## Requirements
- R1: While `start` is high at a clock edge, `sum_q` takes `a_in`, `addend_q` takes `b_in` and `carry_out` becomes 0. After that edge `busy`=1 and `done`=0.
- R2: An accepted step is a clock edge with `busy`=1, `shift_en`=1, `start`=0 and `rearm`=0. On it, `sum_q` shifts right by one bit. Its new bit WIDTH-1 equals the XOR of the old `sum_q[0]`, the old `addend_q[0]` and the old `carry_out`.
- R3: On an accepted step, `carry_out` takes the majority of the old `sum_q[0]`, `addend_q[0]` and `carry_out`.
- R4: On an accepted step, `addend_q` shifts right by one bit and `b_ser_in` enters at bit WIDTH-1. After WIDTH steps, a serial operand fed in least significant bit first sits in `addend_q` in binary order.
- R5: While `busy`=1 and `shift_en`=0 (with `start` and `rearm` low), `sum_q`, `addend_q` and `carry_out` hold their values.
- R6: `done` rises and `busy` falls exactly at the WIDTH-th accepted step after a start or rearm. At that point `sum_q` is (A+B) mod 2^WIDTH and `carry_out` is bit WIDTH of A+B.
- R7: While `busy`=0, `shift_en` has no effect: `sum_q`, `addend_q`, `carry_out` and `done` hold until the next start or rearm.
- R8: While `rearm` is high at a clock edge (with `start` low), `carry_out` becomes 0, `busy` becomes 1 and `done` becomes 0. `sum_q` and `addend_q` keep their values, so the next pass adds the contents of B to the contents of A.
- R9: `start` takes priority over `rearm`, and both take priority over `shift_en`. No step happens in a cycle where either of them is high.
- R10: While `rst_n` is low, `sum_q`, `addend_q` and `carry_out` are 0, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load both operands, clear carry, begin a pass |
| rearm | input | 1 | Clear carry and begin a new pass on the held registers |
| shift_en | input | 1 | Request one bit-serial step |
| a_in | input | WIDTH | Parallel augend |
| b_in | input | WIDTH | Parallel addend |
| b_ser_in | input | 1 | Serial bit entering the top of register B |
| sum_q | output | WIDTH | Contents of register A (running sum) |
| addend_q | output | WIDTH | Contents of register B |
| carry_out | output | 1 | Carry flop; carry of the sum once done |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | WIDTH steps completed, result held |

## Verification
The bench builds the block with WIDTH=8. With that width, the all-ones corners (255+1 and 255+255) fit in a handful of cycles, and the carry ripples through every position of the register. Eight steps per pass also leave room for random gaps in `shift_en`, for `start` and `rearm` arriving mid-pass, and for a two-pass accumulation in which the second operand is fed in serially during the first pass. Random operand pairs from a fixed seed then cover the general sum and carry behaviour.

// File: rtl/serad_pkg.sv
package serad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_FINISHED = 2'd2
    } serad_state_e;

    typedef struct packed {
        logic load;
        logic clr_carry;
        logic step;
    } serad_cmd_t;

endpackage

// File: rtl/serad_shreg.sv
module serad_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        nxt = q;
        if (load) begin
            nxt = load_val;
        end else if (shift) begin
            nxt = {ser_in, q[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/serad_slice.sv
module serad_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic a_bit,
    input  logic b_bit,
    input  logic clr,
    input  logic step,
    output logic sum_bit,
    output logic carry_q
);

    logic carry_nxt;
    logic gen;
    logic prop;

    always_comb begin
        prop      = a_bit ^ b_bit;
        gen       = a_bit & b_bit;
        sum_bit   = prop ^ carry_q;
        carry_nxt = gen | (prop & carry_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (clr) begin
            carry_q <= 1'b0;
        end else if (step) begin
            carry_q <= carry_nxt;
        end
    end

endmodule

// File: rtl/serad_ctrl.sv
module serad_ctrl
    import serad_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rearm,
    input  logic       shift_en,
    output serad_cmd_t cmd,
    output logic       busy,
    output logic       done
);

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    serad_state_e state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          accept;

    always_comb begin
        accept = (state == ST_RUN) && shift_en && !start && !rearm;
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (start || rearm) begin
                    state_nxt = ST_RUN;
                    cnt_nxt   = '0;
                end
            end
            ST_RUN: begin
                if (start || rearm) begin
                    cnt_nxt = '0;
                end else if (accept) begin
                    if (cnt == LAST) begin
                        state_nxt = ST_FINISHED;
                    end
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_FINISHED: begin
                if (start || rearm) begin
                    state_nxt = ST_RUN;
                    cnt_nxt   = '0;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        cmd.load      = start;
        cmd.clr_carry = start | rearm;
        cmd.step      = accept;
        busy          = (state == ST_RUN);
        done          = (state == ST_FINISHED);
    end

endmodule

// File: rtl/serad_top.sv
module serad_top
    import serad_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rearm,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_ser_in,
    output logic [WIDTH-1:0] sum_q,
    output logic [WIDTH-1:0] addend_q,
    output logic             carry_out,
    output logic             busy,
    output logic             done
);

    serad_cmd_t cmd;
    logic       sum_bit;

    serad_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rearm    (rearm),
        .shift_en (shift_en),
        .cmd      (cmd),
        .busy     (busy),
        .done     (done)
    );

    serad_shreg #(.WIDTH(WIDTH)) u_reg_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd.load),
        .load_val (a_in),
        .shift    (cmd.step),
        .ser_in   (sum_bit),
        .q        (sum_q)
    );

    serad_shreg #(.WIDTH(WIDTH)) u_reg_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd.load),
        .load_val (b_in),
        .shift    (cmd.step),
        .ser_in   (b_ser_in),
        .q        (addend_q)
    );

    serad_slice u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_bit   (sum_q[0]),
        .b_bit   (addend_q[0]),
        .clr     (cmd.clr_carry),
        .step    (cmd.step),
        .sum_bit (sum_bit),
        .carry_q (carry_out)
    );

endmodule

// File: rtl/serad_checker.sv
module serad_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rearm,
    input logic             shift_en,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             b_ser_in,
    input logic [WIDTH-1:0] sum_q,
    input logic [WIDTH-1:0] addend_q,
    input logic             carry_out,
    input logic             busy,
    input logic             done
);

    localparam int CW = $clog2(WIDTH + 1);

    logic          acc;
    logic [CW-1:0] chk_cnt;

    assign acc = busy && shift_en && !start && !rearm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_cnt <= '0;
        end else if (start || rearm) begin
            chk_cnt <= '0;
        end else if (acc) begin
            chk_cnt <= chk_cnt + 1'b1;
        end
    end

    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!rst_n -> (sum_q == '0 && addend_q == '0 && !carry_out && !busy && !done)));

    assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sum_q == $past(a_in) && addend_q == $past(b_in) && !carry_out && busy && !done));

    assert_sum_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (sum_q[WIDTH-1] == ($past(sum_q[0]) ^ $past(addend_q[0]) ^ $past(carry_out))
                 && sum_q[WIDTH-2:0] == $past(sum_q[WIDTH-1:1])));

    assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> carry_out == (($past(sum_q[0]) & $past(addend_q[0])) |
                              ($past(carry_out) & ($past(sum_q[0]) | $past(addend_q[0])))));

    assert_b_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> addend_q == {$past(b_ser_in), $past(addend_q[WIDTH-1:1])});

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_en && !start && !rearm) |=>
            ($stable(sum_q) && $stable(addend_q) && $stable(carry_out)));

    assert_done_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_cnt == CW'(WIDTH)));

    assert_busy_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (chk_cnt < CW'(WIDTH)));

    assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && !rearm) |=>
            ($stable(sum_q) && $stable(addend_q) && $stable(carry_out) && $stable(done)));

    assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm && !start) |=>
            ($stable(sum_q) && $stable(addend_q) && !carry_out && busy && !done));

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

endmodule

bind serad_top serad_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rearm     (rearm),
    .shift_en  (shift_en),
    .a_in      (a_in),
    .b_in      (b_in),
    .b_ser_in  (b_ser_in),
    .sum_q     (sum_q),
    .addend_q  (addend_q),
    .carry_out (carry_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_serad_top.sv
module sim_serad_top;

    localparam int W      = 8;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         rearm = 1'b0;
    logic         shift_en = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         b_ser_in = 1'b0;
    logic [W-1:0] sum_q;
    logic [W-1:0] addend_q;
    logic         carry_out;
    logic         busy;
    logic         done;

    int errors = 0;
    int checks = 0;
    int unsigned seed = 32'd20240517;
    int unsigned dummy;

    logic [W-1:0] ma, mb;
    logic         mc, mbusy, mdone;
    int           mcnt;

    always #(PERIOD/2) clk = ~clk;

    serad_top #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rearm(rearm),
        .shift_en(shift_en), .a_in(a_in), .b_in(b_in), .b_ser_in(b_ser_in),
        .sum_q(sum_q), .addend_q(addend_q), .carry_out(carry_out),
        .busy(busy), .done(done)
    );

    function automatic logic [W-1:0] exp_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[W-1:0];
    endfunction

    function automatic logic exp_carry(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[W];
    endfunction

    task automatic check(input string req, input logic [W+2:0] act, input logic [W+2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, compare shortly after
    task automatic step(input logic st, input logic ra, input logic sh, input logic ser,
                        input logic [W-1:0] a, input logic [W-1:0] b);
        logic s, c, took;
        string tag;
        @(negedge clk);
        start = st; rearm = ra; shift_en = sh; b_ser_in = ser; a_in = a; b_in = b;
        @(posedge clk);
        took = 1'b0;
        if (st) begin
            ma = a; mb = b; mc = 1'b0; mcnt = 0; mbusy = 1'b1; mdone = 1'b0;
            tag = (ra || sh) ? "R9" : "R1";
        end else if (ra) begin
            mc = 1'b0; mcnt = 0; mbusy = 1'b1; mdone = 1'b0;
            tag = sh ? "R9" : "R8";
        end else if (sh && mbusy) begin
            s = ma[0] ^ mb[0] ^ mc;
            c = (ma[0] & mb[0]) | (mc & (ma[0] | mb[0]));
            ma = {s, ma[W-1:1]};
            mb = {ser, mb[W-1:1]};
            mc = c;
            mcnt++;
            took = 1'b1;
            if (mcnt == W) begin
                mbusy = 1'b0; mdone = 1'b1;
            end
            tag = "R2";
        end else if (!mbusy) begin
            tag = "R7";
        end else begin
            tag = "R5";
        end
        #2;
        check(tag, {3'b0, sum_q}, {3'b0, ma});
        check(took ? "R4" : tag, {3'b0, addend_q}, {3'b0, mb});
        check(took ? "R3" : tag, {{(W+2){1'b0}}, carry_out}, {{(W+2){1'b0}}, mc});
        check("R6", {{(W+1){1'b0}}, busy, done}, {{(W+1){1'b0}}, mbusy, mdone});
    endtask

    // full pass: start, then W accepted steps with optional random gaps
    task automatic add_pass(input logic [W-1:0] a, input logic [W-1:0] b, input bit gaps);
        step(1'b1, 1'b0, 1'b0, 1'b0, a, b);
        for (int k = 0; k < W; k++) begin
            if (gaps) begin
                while (($urandom() % 3) == 0) step(1'b0, 1'b0, 1'b0, 1'($urandom()), '0, '0);
            end
            step(1'b0, 1'b0, 1'b1, 1'($urandom()), '0, '0);
        end
        check("R6", {2'b0, done, sum_q}, {2'b0, 1'b1, exp_sum(a, b)});
        check("R6", {{(W+2){1'b0}}, carry_out}, {{(W+2){1'b0}}, exp_carry(a, b)});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [W-1:0] x, y, hold_a, hold_b;
        dummy = $urandom(seed);
        ma = '0; mb = '0; mc = 1'b0; mbusy = 1'b0; mdone = 1'b0; mcnt = 0;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10", {busy, done, carry_out, sum_q}, '0);
        check("R10", {3'b0, addend_q}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: shift requests in IDLE are ignored
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h55);
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 8'h55);

        // directed corners, R6
        add_pass(8'hFF, 8'h01, 1'b0);
        add_pass(8'hFF, 8'hFF, 1'b0);
        add_pass(8'h00, 8'h00, 1'b0);
        add_pass(8'h80, 8'h80, 1'b1);

        // R7: after done, further shifts leave result untouched
        hold_a = sum_q; hold_b = addend_q;
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b1, 1'b1, '0, '0);
        check("R7", {2'b0, done, sum_q}, {2'b0, 1'b1, hold_a});
        check("R7", {3'b0, addend_q}, {3'b0, hold_b});

        // R8 + R4: accumulate x then y, y fed serially during the first pass
        x = 8'hC9; y = 8'h5E;
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, x);
        for (int k = 0; k < W; k++) step(1'b0, 1'b0, 1'b1, y[k], '0, '0);
        check("R4", {3'b0, addend_q}, {3'b0, y});
        check("R8", {3'b0, sum_q}, {3'b0, x});
        step(1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
        for (int k = 0; k < W; k++) step(1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
        check("R8", {2'b0, done, sum_q}, {2'b0, 1'b1, exp_sum(x, y)});
        check("R8", {{(W+2){1'b0}}, carry_out}, {{(W+2){1'b0}}, exp_carry(x, y)});

        // R9: start with rearm and shift mid-pass; rearm with shift mid-pass
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h37, 8'h11);
        step(1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
        step(1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h4B);
        for (int k = 0; k < W; k++) step(1'b0, 1'b0, 1'b1, 1'b0, '0, '0);
        check("R9", {2'b0, done, sum_q}, {2'b0, 1'b1, exp_sum(8'h3C, 8'h4B)});
        step(1'b0, 1'b1, 1'b1, 1'b0, '0, '0);
        check("R9", {{(W+1){1'b0}}, busy, done}, {{(W+1){1'b0}}, 2'b10});

        // random passes
        for (int t = 0; t < 40; t++) begin
            add_pass(W'($urandom()), W'($urandom()), 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule